// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block is the processor-facing half of an interrupt controller. It takes a set of interrupt source lines, a per-source trigger setting (edge or level) and a per-source priority. From these it picks the single most urgent interrupt that this CPU may take. The CPU sees that choice as an IRQ line. Software reads an acknowledge register to claim the chosen interrupt, and later writes the same ID to an end-of-interrupt register to retire it.

Rising edges are latched for edge sources; level sources are pending for as long as their line is high. A claimed interrupt becomes active, and the priority it had when claimed is recorded. The lowest recorded priority among the active interrupts is the running priority. A new interrupt is signalled only when it beats both the priority mask and the running priority. Register access uses a simple one-cycle strobe: a read has its side effects at the clock edge that ends the strobe, and its data is returned combinationally during that cycle.

Top module: `irq_ack_port`

## Requirements
- R1: After reset the control register (address 0, bit 0 = enable) reads 0, the priority mask (address 1, low PRIO_W bits) reads 0, `irq_o` is low and an acknowledge read (address 2) returns 1023.
- R2: An acknowledge read returns the selected interrupt ID in bits [9:0] with bits [31:10] zero. The numerically lowest priority wins, and among equal priorities the lowest ID wins.
- R3: When no interrupt is eligible, an acknowledge read returns 1023 and changes no state.
- R4: An interrupt is eligible only if its priority is numerically below the mask, so a priority equal to the mask is blocked.
- R5: While control bit 0 is 0, `irq_o` stays low and acknowledge reads return 1023.
- R6: Acknowledging an edge source clears its latched pending state. A rising edge on that source in the same cycle as the acknowledge leaves it pending.
- R7: An acknowledged interrupt is active and is not offered again until an end-of-interrupt write (address 3, ID in bits [9:0]) names it. A level source that is still high after that write is offered again.
- R8: An end-of-interrupt write whose ID is not currently active changes nothing.
- R9: `irq_o` is high exactly when an eligible interrupt has a priority strictly below the running priority, taken as the minimum over active interrupts or as no limit when none is active. An equal priority does not preempt.
- R10: With `edge_i` = 1, a rising edge latches pending even if the line falls again at once. With `edge_i` = 0, pending follows the line level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | N_SRC | Interrupt source lines |
| edge_i | input | N_SRC | Per-source trigger: 1 edge, 0 level |
| prio_i | input | N_SRC*PRIO_W | Per-source priority, source k at [k*PRIO_W +: PRIO_W] |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 2 | 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while the strobe is high |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Two functions can meet in one cycle: the acknowledge that clears an edge source's pending state, and a new rising edge on that same source. The bench drops the line beforehand, then raises it again during the very cycle of the acknowledge read. After the end-of-interrupt, the behavioural model and the design must both offer that source once more. A design where the clear wins would lose the second edge and return 1023 there.

// File: rtl/irq_ack_port.sv
module irq_ack_port #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SRC-1:0]          src_i,
  input  logic [N_SRC-1:0]          edge_i,
  input  logic [N_SRC*PRIO_W-1:0]   prio_i,
  input  logic                      bus_sel_i,
  input  logic                      bus_wr_i,
  input  logic [1:0]                bus_addr_i,
  input  logic [31:0]               bus_wdata_i,
  output logic [31:0]               bus_rdata_o,
  output logic                      irq_o
);
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPUR = ID_W'(1023);
  localparam logic [1:0] A_CTRL = 2'd0, A_MASK = 2'd1, A_ACK = 2'd2, A_EOI = 2'd3;

  logic [N_SRC-1:0]  src_q, pend_q, active_q;
  logic [PRIO_W-1:0] act_prio_q [N_SRC];
  logic              ctrl_q;
  logic [PRIO_W-1:0] mask_q;

  logic [N_SRC-1:0]  rise, cand, ack_hit, eoi_hit;
  logic              best_v, eligible, ack_take, eoi_wr;
  logic [ID_W-1:0]   best_id, ack_id;
  logic [PRIO_W-1:0] best_prio;
  logic [PRIO_W:0]   run_prio;

  assign rise = src_i & ~src_q;
  assign cand = ~active_q & ((edge_i & pend_q) | (~edge_i & src_i));

  always_comb begin
    best_v    = 1'b0;
    best_id   = SPUR;
    best_prio = '1;
    run_prio  = {1'b1, {PRIO_W{1'b0}}};
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!best_v || prio_i[i*PRIO_W +: PRIO_W] < best_prio)) begin
        best_v    = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
      end
      if (active_q[i] && {1'b0, act_prio_q[i]} < run_prio)
        run_prio = {1'b0, act_prio_q[i]};
    end
  end

  assign eligible = ctrl_q && best_v && (best_prio < mask_q) && ({1'b0, best_prio} < run_prio);
  assign ack_id   = eligible ? best_id : SPUR;
  assign irq_o    = eligible;
  assign ack_take = bus_sel_i && !bus_wr_i && bus_addr_i == A_ACK && eligible;
  assign eoi_wr   = bus_sel_i && bus_wr_i && bus_addr_i == A_EOI;

  always_comb begin
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o = {31'd0, ctrl_q};
      A_MASK:  bus_rdata_o = 32'(mask_q);
      A_ACK:   bus_rdata_o = {22'd0, ack_id};
      default: bus_rdata_o = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
      mask_q <= '0;
      src_q  <= '0;
    end else begin
      src_q <= src_i;
      if (bus_sel_i && bus_wr_i && bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i[0];
      if (bus_sel_i && bus_wr_i && bus_addr_i == A_MASK) mask_q <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign ack_hit[g] = ack_take && best_id == ID_W'(g);
    assign eoi_hit[g] = eoi_wr && bus_wdata_i[ID_W-1:0] == ID_W'(g) && active_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g]     <= 1'b0;
        active_q[g]   <= 1'b0;
        act_prio_q[g] <= '0;
      end else begin
        pend_q[g] <= edge_i[g] & (rise[g] | (pend_q[g] & ~ack_hit[g]));
        if (ack_hit[g]) begin
          active_q[g]   <= 1'b1;
          act_prio_q[g] <= prio_i[g*PRIO_W +: PRIO_W];
        end else if (eoi_hit[g]) begin
          active_q[g]   <= 1'b0;
        end
      end
    end
  end
endmodule

module irq_ack_port_chk #(
  parameter int N_SRC = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel_i,
  input logic             bus_wr_i,
  input logic [1:0]       bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic [31:0]      bus_rdata_o,
  input logic             irq_o,
  input logic [N_SRC-1:0] active_q
);
  logic ack_rd, eoi_wr, eoi_miss;
  assign ack_rd = bus_sel_i && !bus_wr_i && bus_addr_i == 2'd2;
  assign eoi_wr = bus_sel_i && bus_wr_i && bus_addr_i == 2'd3;

  always_comb begin
    eoi_miss = 1'b1;
    for (int i = 0; i < N_SRC; i++)
      if (active_q[i] && bus_wdata_i[9:0] == 10'(i)) eoi_miss = 1'b0;
  end

  AST_ACK_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ack_rd |-> bus_rdata_o[31:10] == 22'd0); // R2
  AST_IRQ_GIVES_ID: assert property (@(posedge clk) disable iff (rst)
    ack_rd && irq_o |-> bus_rdata_o[9:0] != 10'd1023); // R2
  AST_QUIET_IS_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    ack_rd && !irq_o |-> bus_rdata_o[9:0] == 10'd1023); // R3
  AST_SPURIOUS_NO_STATE: assert property (@(posedge clk) disable iff (rst)
    ack_rd && !irq_o |=> $stable(active_q)); // R3
  AST_DISABLE_SILENCES: assert property (@(posedge clk) disable iff (rst)
    bus_sel_i && bus_wr_i && bus_addr_i == 2'd0 && !bus_wdata_i[0] |=> !irq_o); // R5
  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
    ack_rd && irq_o |=> $countones(active_q) == $countones($past(active_q)) + 1); // R7
  AST_EOI_MISS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    eoi_wr && eoi_miss |=> $stable(active_q)); // R8
endmodule

bind irq_ack_port irq_ack_port_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .irq_o(irq_o), .active_q(active_q)
);

// File: tb/irq_ack_port_test.sv
`timescale 1ns/1ps
module irq_ack_port_test;
  localparam int N = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src = '0, edg = '0;
  logic [N*PW-1:0] prio = '0;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_pend[N], m_srcq[N], m_act[N];
  int m_actp[N];
  bit m_ctrl;
  int m_mask;

  always #10 clk = ~clk;

  irq_ack_port #(.N_SRC(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .src_i(src), .edge_i(edg), .prio_i(prio),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pr(input int k);
    return int'(prio[k*PW +: PW]);
  endfunction

  task automatic model_pick(output bit elig, output int id);
    int bp, run;
    bit bv;
    bv = 0; bp = 0; id = 1023; run = 256;
    for (int k = 0; k < N; k++) begin
      bit c;
      c = !m_act[k] && (edg[k] ? m_pend[k] : src[k]);
      if (c && (!bv || pr(k) < bp)) begin bv = 1; bp = pr(k); id = k; end
      if (m_act[k] && m_actp[k] < run) run = m_actp[k];
    end
    elig = m_ctrl && bv && bp < m_mask && bp < run;
    if (!elig) id = 1023;
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      m_pend[k] = 0; m_srcq[k] = 0; m_act[k] = 0; m_actp[k] = 0;
    end
    m_ctrl = 0; m_mask = 0;
  endtask

  // one bus cycle; inputs already set for src/prio; compares every clock
  task automatic step(input bit s, input bit w, input int a, input int d, input string tag);
    bit elig;
    int id;
    sel = s; wr = w; addr = 2'(a); wdata = 32'(d);
    #1;
    model_pick(elig, id);
    check(irq == elig, {tag, " irq"}, int'(irq), int'(elig));
    if (s && !w) begin
      int exp;
      case (a)
        0: exp = int'(m_ctrl);
        1: exp = m_mask;
        2: exp = id;
        default: exp = 0;
      endcase
      check(rdata == 32'(exp), {tag, " rdata"}, int'(rdata), exp);
    end
    for (int k = 0; k < N; k++) begin
      bit rise, hit;
      rise = src[k] && !m_srcq[k];
      hit = s && !w && a == 2 && elig && id == k;
      m_pend[k] = edg[k] && (rise || (m_pend[k] && !hit));
      if (hit) begin m_act[k] = 1; m_actp[k] = pr(k); end
      else if (s && w && a == 3 && (d & 1023) == k) m_act[k] = 0;
      m_srcq[k] = src[k];
    end
    if (s && w && a == 0) m_ctrl = d[0];
    if (s && w && a == 1) m_mask = d & 255;
    @(posedge clk);
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, tag);
  endtask

  task automatic ack(input int exp, input string tag);
    bit elig;
    int id;
    #1;
    model_pick(elig, id);
    check(id == exp, {tag, " scenario-ack"}, id, exp);
    step(1, 0, 2, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    edg = 8'b0011_0000;
    for (int k = 0; k < N; k++) prio[k*PW +: PW] = 8'hA0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    step(1, 0, 0, 0, "R1 ctrl");
    step(1, 0, 1, 0, "R1 mask");
    ack(1023, "R1 ack");
    // enable, mask F0 admits A0 (R4)
    step(1, 1, 0, 1, "R5 enable");
    step(1, 1, 1, 32'hF0, "R4 mask");
    step(1, 0, 0, 0, "R5 ctrl read");
    // R10 level 3 and short edge pulse on 5
    src[3] = 1; src[5] = 1;
    idle("R10 raise");
    src[5] = 0;
    idle("R10 edge latched");
    ack(3, "R2 tie lowest id");
    idle("R9 equal no preempt");
    ack(1023, "R3 spurious");
    step(1, 1, 3, 6, "R8 eoi inactive");
    ack(1023, "R8 still active");
    step(1, 1, 3, 3, "R7 eoi");
    ack(3, "R7 level reoffered");
    src[3] = 0;
    step(1, 1, 3, 3, "R7 eoi again");
    ack(5, "R10 edge pending");
    step(1, 1, 3, 5, "R6 eoi 5");
    ack(1023, "R6 pending cleared");
    // R9 preemption
    prio[6*PW +: PW] = 8'hC0; prio[2*PW +: PW] = 8'h40;
    src[6] = 1;
    idle("R9 low prio");
    ack(6, "R9 take 6");
    src[2] = 1;
    idle("R9 preempt");
    ack(2, "R9 take 2");
    step(1, 1, 3, 2, "R9 eoi 2");
    src[2] = 0;
    step(1, 1, 3, 6, "R9 eoi 6");
    src[6] = 0;
    idle("R9 quiet");
    // R4 mask equality blocks
    prio[1*PW +: PW] = 8'hF0;
    src[1] = 1;
    idle("R4 blocked");
    ack(1023, "R4 equal mask");
    step(1, 1, 1, 32'hF1, "R4 widen mask");
    step(1, 0, 1, 0, "R4 mask read");
    // R5 disable
    step(1, 1, 0, 0, "R5 disable");
    ack(1023, "R5 disabled ack");
    step(1, 1, 0, 1, "R5 enable again");
    ack(1, "R4 admitted");
    src[1] = 0;
    step(1, 1, 3, 1, "R7 eoi 1");
    // R6 collision: new rise on edge source 4 during its acknowledge
    src[4] = 1;
    idle("R6 rise");
    src[4] = 0;
    idle("R6 low");
    src[4] = 1;
    ack(4, "R6 ack with rise");
    src[4] = 0;
    step(1, 1, 3, 4, "R6 eoi 4");
    ack(4, "R6 second edge kept");
    step(1, 1, 3, 4, "R6 final eoi");
    ack(1023, "R6 drained");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      src = 8'($urandom);
      for (int k = 0; k < N; k++) if ($urandom % 8 == 0) prio[k*PW +: PW] = 8'($urandom % 4 * 64);
      op = $urandom % 6;
      case (op)
        0: step(1, 0, 2, 0, "R2 R9 mixed ack");
        1: step(1, 1, 3, ($urandom % 3 == 0) ? 1023 : int'($urandom % 10), "R7 R8 mixed eoi");
        2: step(1, 1, 1, int'($urandom % 256), "R4 mixed mask");
        3: step(1, 1, 0, ($urandom % 5 == 0) ? 0 : 1, "R5 mixed ctrl");
        default: step(0, 0, 0, 0, "R10 mixed idle");
      endcase
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule